// File: doc/BRIEF.md
# Sentinel-Terminated Upward Word Copier

This block moves a run of 32-bit words from the bottom of a memory to a region a fixed distance higher in the same memory. It uses one memory port that has separate read and write addresses. After a synchronous reset it reads word 0, then word 1, and so on, issuing one read address per cycle. The memory returns each word one cycle after its address. The block writes that word back at its own address plus 0x40, with every byte enabled. The block does not count words. The run ends when a read returns the all-ones word 0xFFFFFFFF. That marker word is not copied.

Reads also stop once the read address reaches the destination offset. A source region with no marker therefore stops after 64 words and never reads data the block has already written. When the block stops, it drives an active-low done line. That line stays low until the next reset, so a free-running clock can be halted on it. After that the block sits idle with its byte enables at zero. Every flip-flop uses a synchronous reset.

Top module: `sentinel_copy_engine`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `rd_addr` = 0, `done_n` = 1 and `wr_be` = 4'b0000.
- R2: After reset is released, `rd_addr` equals the number of rising edges since release (0, 1, 2, …) until the stop condition is seen. Reads never pass address 0x40.
- R3: The word the memory returns for read address A appears on `wr_data` one cycle after A was driven, with `wr_addr` = A + 0x40 in that same cycle, so it lands at A + 0x40.
- R4: `wr_be` is 4'b1111 in a cycle that writes and 4'b0000 in every other cycle.
- R5: When the returned word is 0xFFFFFFFF, it is not written and no later writes occur. The destination of the marker keeps its previous content, and the number of writes equals the marker's address.
- R6: `done_n` goes low on the edge after the cycle in which the marker word is presented, so it is first seen low S+2 rising edges after reset release for a marker at address S.
- R7: If none of words 0 to 0x3F is the marker, all 64 words are copied and `done_n` is first seen low 65 edges after release.
- R8: Once `done_n` is low, it stays low, `wr_be` stays zero and `rd_addr` holds, until reset.
- R9: Asserting `rst` in the middle of a copy returns `rd_addr` to 0 and `done_n` to 1. After release, the copy starts again from address 0.
- R10: A word that differs from 0xFFFFFFFF in any single bit is copied like ordinary data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the memory |
| rst | input | 1 | Synchronous reset, active high |
| rd_addr | output | 8 | Memory read word address |
| rd_data | input | 32 | Memory read data, one cycle after `rd_addr` |
| wr_addr | output | 8 | Memory write word address |
| wr_data | output | 32 | Memory write data |
| wr_be | output | 4 | Byte write enables, all ones on a write |
| done_n | output | 1 | Active-low finished/breakpoint flag, held until reset |

## Verification
The hardest case to reach is the stop at the read limit. It only happens when 64 consecutive source words contain no all-ones word. It also coincides with the final write to 0x7F. The vector table includes a case with no marker in the whole source region and a case with the marker at address 0x3F, where the marker check and the limit check fire in the same cycle. A pattern of words that each have one bit cleared covers near-marker data. A mid-run reset shows that the address and the done flag restart cleanly.

// File: rtl/copy_engine_pkg.sv
package copy_engine_pkg;
  typedef enum logic [0:0] {PH_RUN = 1'b0, PH_HALT = 1'b1} phase_t;

  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_ADDR_W = 8;
  localparam int unsigned DEF_OFFSET = 64;
endpackage

// File: rtl/copy_read_seq.sv
module copy_read_seq #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LIMIT  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halted,
  input  logic              stop_now,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              issue
);
  localparam logic [ADDR_W-1:0] LIM_A = ADDR_W'(LIMIT);

  logic [ADDR_W-1:0] addr_q;

  assign issue   = !halted && !stop_now && (addr_q < LIM_A);
  assign rd_addr = addr_q;

  always_ff @(posedge clk) begin
    if (rst)        addr_q <= '0;
    else if (issue) addr_q <= addr_q + ADDR_W'(1);
  end

  // R2: every issued read advances the address by exactly one
  a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
    issue |=> (addr_q == $past(addr_q) + ADDR_W'(1)));

  // R2: reads never go beyond the limit
  a_r2_read_bound: assert property (@(posedge clk) disable iff (rst)
    addr_q <= LIM_A);
endmodule

// File: rtl/copy_data_pipe.sv
module copy_data_pipe #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFFSET = 64,
  parameter int unsigned LIMIT  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              halted,
  output logic              pend,
  output logic              hit_mark,
  output logic              at_last,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LIMIT - 1);

  function automatic logic is_mark(input logic [DATA_W-1:0] w);
    return &w;
  endfunction

  function automatic logic [ADDR_W-1:0] dest_of(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(OFFSET);
  endfunction

  logic              pend_q;
  logic [ADDR_W-1:0] src_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      src_q  <= '0;
    end else begin
      pend_q <= issue;
      if (issue) src_q <= rd_addr;
    end
  end

  assign pend     = pend_q;
  assign hit_mark = pend_q && is_mark(rd_data);
  assign at_last  = pend_q && (src_q == LAST_A);
  assign wr_en    = pend_q && !hit_mark && !halted;
  assign wr_addr  = dest_of(src_q);
  assign wr_data  = rd_data;

  // R3: a pending word always belongs to the address issued one cycle before
  a_r3_src_tracks: assert property (@(posedge clk) disable iff (rst)
    issue |=> (pend && src_q == $past(rd_addr)));

  // R5: the marker never turns into a write
  a_r5_mark_blocks: assert property (@(posedge clk) disable iff (rst)
    hit_mark |-> !wr_en);
endmodule

// File: rtl/copy_stop_ctrl.sv
module copy_stop_ctrl
  import copy_engine_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pend,
  input  logic hit_mark,
  input  logic at_last,
  output logic stop_now,
  output logic halted,
  output logic done_n
);
  phase_t phase_q;

  assign stop_now = pend && (hit_mark || at_last) && (phase_q == PH_RUN);
  assign halted   = (phase_q == PH_HALT);
  assign done_n   = !halted;

  always_ff @(posedge clk) begin
    if (rst)           phase_q <= PH_RUN;
    else if (stop_now) phase_q <= PH_HALT;
  end

  // R8: the halt phase is sticky until reset
  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R6: a marker seen while running ends the run on the next edge
  a_r6_mark_halts: assert property (@(posedge clk) disable iff (rst)
    (pend && hit_mark) |=> halted);
endmodule

// File: rtl/sentinel_copy_engine.sv
module sentinel_copy_engine
  import copy_engine_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned OFFSET = DEF_OFFSET
) (
  input  logic                clk,
  input  logic                rst,
  output logic [ADDR_W-1:0]   rd_addr,
  input  logic [DATA_W-1:0]   rd_data,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W/8-1:0] wr_be,
  output logic                done_n
);
  localparam int unsigned BE_W  = DATA_W / 8;
  localparam int unsigned LIMIT = OFFSET;

  logic issue, stop_now, halted;
  logic pend, hit_mark, at_last, wr_en;

  copy_read_seq #(.ADDR_W(ADDR_W), .LIMIT(LIMIT)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .halted   (halted),
    .stop_now (stop_now),
    .rd_addr  (rd_addr),
    .issue    (issue)
  );

  copy_data_pipe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFSET(OFFSET), .LIMIT(LIMIT)) u_pipe (
    .clk      (clk),
    .rst      (rst),
    .issue    (issue),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .halted   (halted),
    .pend     (pend),
    .hit_mark (hit_mark),
    .at_last  (at_last),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  copy_stop_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .pend     (pend),
    .hit_mark (hit_mark),
    .at_last  (at_last),
    .stop_now (stop_now),
    .halted   (halted),
    .done_n   (done_n)
  );

  assign wr_be = wr_en ? {BE_W{1'b1}} : {BE_W{1'b0}};

  // R1: reset clears the address and the done flag
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (rd_addr == '0 && done_n && wr_be == '0));

  // R3: a write goes to the previous read address plus the offset
  a_r3_dest_addr: assert property (@(posedge clk) disable iff (rst)
    (|wr_be) |-> (wr_addr == $past(rd_addr) + ADDR_W'(OFFSET)));

  // R5: the all-ones word never appears with enabled bytes
  a_r5_no_mark_write: assert property (@(posedge clk) disable iff (rst)
    (|wr_be) |-> !(&wr_data));

  // R8: nothing is written and the address holds once done
  a_r8_idle_when_done: assert property (@(posedge clk) disable iff (rst)
    (!done_n) |-> (wr_be == '0 && $stable(rd_addr)));

  // R6: done, once low, stays low
  a_r6_done_held: assert property (@(posedge clk) disable iff (rst)
    (!done_n) |=> !done_n);
endmodule

// File: tb/tb_sentinel_copy_engine.sv
module tb_sentinel_copy_engine;
  localparam int unsigned OFS   = 64;
  localparam int unsigned NCASE = 7;
  // each row: marker address (64 = none), data pattern seed
  localparam int unsigned CASES [NCASE][2] = '{
    '{5, 7}, '{0, 3}, '{1, 2}, '{17, 1}, '{63, 9}, '{64, 11}, '{40, 1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  rd_addr, wr_addr;
  logic [31:0] rd_data, wr_data;
  logic [3:0]  wr_be;
  logic        done_n;

  logic [31:0] mem [256];
  int          total = 0;
  int          bad   = 0;
  int          wcount = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  sentinel_copy_engine dut (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be), .done_n(done_n)
  );

  always @(posedge clk) begin
    rd_data <= mem[rd_addr];
    for (int b = 0; b < 4; b++)
      if (wr_be[b]) mem[wr_addr][8*b +: 8] <= wr_data[8*b +: 8];
    if (!rst && wr_be != 4'b0000) wcount++;
  end

  function automatic logic [31:0] pat(int unsigned seed, int unsigned i);
    logic [31:0] v;
    if (seed == 1) return ~(32'h1 << (i % 32));
    v = seed * 32'h9E3779B1 + i * 32'h01000193;
    if (v == 32'hFFFF_FFFF) v = 32'h0;
    return v;
  endfunction

  function automatic logic [31:0] canary(int unsigned i);
    return 32'hC0DE_0000 | i;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(int unsigned s, int unsigned seed);
    for (int i = 0; i < 256; i++) mem[i] = canary(i);
    for (int i = 0; i < 64; i++) mem[i] = pat(seed, i);
    if (s < 64) mem[s] = 32'hFFFF_FFFF;
  endtask

  task automatic hold_reset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    wcount = 0;
    rst = 1'b0;
  endtask

  task automatic run_case(int unsigned s, int unsigned seed);
    int unsigned exp_edges, exp_writes, edges, bad_addr, bad_wr, k;
    logic [7:0] held;
    exp_edges  = (s < 64) ? s + 2 : 65;
    exp_writes = (s < 64) ? s : 64;
    load(s, seed);
    hold_reset();
    edges = 0; bad_addr = 0; bad_wr = 0;
    while (done_n === 1'b1 && edges < 200) begin
      @(posedge clk); edges++;
      @(negedge clk);
      k = edges;
      if (k <= ((s + 1 < 64) ? s + 1 : 64) && rd_addr !== 8'(k)) bad_addr++;
      if (wr_be !== 4'b0000) begin
        if (wr_be !== 4'b1111) bad_wr++;
        if (wr_addr !== 8'(k - 1 + OFS)) bad_wr++;
        if (wr_data !== pat(seed, k - 1)) bad_wr++;
      end
    end
    check("R2 read address sequence", bad_addr, 0);
    check("R3/R4 write address data enables", bad_wr, 0);
    if (s < 64) check("R6 done edge count", edges, exp_edges);
    else        check("R7 done at read limit", edges, exp_edges);
    check("R5 write count", wcount, exp_writes);
    begin
      int unsigned cbad = 0;
      for (int i = 0; i < 64; i++) begin
        if (i < exp_writes) begin
          if (mem[OFS + i] !== pat(seed, i)) cbad++;
        end else if (mem[OFS + i] !== canary(OFS + i)) cbad++;
      end
      if (seed == 1) check("R10 near-marker words copied", cbad, 0);
      else           check("R3/R5 destination contents", cbad, 0);
    end
    held = rd_addr;
    begin
      int unsigned ibad = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (done_n !== 1'b0 || wr_be !== 4'b0000 || rd_addr !== held) ibad++;
      end
      check("R8 idle after done", ibad, 0);
    end
  endtask

  initial begin
    load(64, 5);
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R1 reset rd_addr", rd_addr, 0);
    check("R1 reset done_n", done_n, 1);
    check("R1 reset wr_be", wr_be, 0);

    for (int c = 0; c < NCASE; c++) run_case(CASES[c][0], CASES[c][1]);

    // R9: reset in the middle of a run
    load(30, 4);
    hold_reset();
    for (int i = 0; i < 10; i++) @(posedge clk);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R9 mid-run reset rd_addr", rd_addr, 0);
    check("R9 mid-run reset done_n", done_n, 1);
    check("R9 mid-run reset wr_be", wr_be, 0);
    run_case(30, 4);
    finished = 1'b1;
  end

  initial begin
    int unsigned n = 0;
    while (!finished && n < 20000) begin
      @(posedge clk); n++;
    end
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=done", n);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule